// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is the control logic of a small direct-mapped write-back cache placed between a processor and a slow external memory. The cached data sit in a separate 256-word SRAM, and the block only steers it. The controller splits each processor address into a tag, a line index and a word offset. It keeps a tag, a valid flag and a dirty flag for each of the 8 lines, and decides on every selected access whether it hits.

A hit is answered in the same cycle. A read hit completes with no memory traffic. A write hit also writes the SRAM word and marks the line dirty. On a miss the controller inspects the victim line. A clean victim is refilled at once. A dirty victim is first copied out word by word, and the line is then refilled. Each line transfer moves 32 words. Every word gets a single-cycle memory strobe followed by a fixed, parameterised wait that models memory latency. Two select outputs tell the external data path whether the SRAM is being loaded from memory or memory is being loaded from the SRAM. The processor must hold its address, direction and select stable until it sees ready.

Top module: `cache_ctrl_top`

## Requirements
- R1: Address bits 15..8 are the tag, bits 7..5 the line index and bits 4..0 the word offset. An access hits when the indexed line is valid and its stored tag equals the address tag. On a hit `cpu_ready` is high in the same cycle and `mem_stb` stays low.
- R2: After a synchronous reset (`rst` high at a clock edge) every line is invalid, so the first access to any line misses. With `cpu_sel` low, `cpu_ready` is 1 and `mem_stb`, `cram_we`, `fill_sel` and `wb_sel` are 0.
- R3: A miss on a clean or invalid line issues exactly 32 memory reads (`mem_stb`=1, `mem_we`=0). The word numbers rise from 0 to 31, and `mem_addr` = {address tag, index, word}. `cpu_ready` rises 2+32*(WAIT_CYC+1) cycles after the access is first presented.
- R4: During a refill, `cram_we` pulses once per word, WAIT_CYC cycles after that word's strobe. It writes `cram_addr` = {index, word} with `fill_sel` high. A refill stores the new tag, sets valid and clears dirty.
- R5: A miss on a dirty line first issues 32 memory writes (`mem_stb`=1, `mem_we`=1). These use `mem_addr` = {stored tag, index, word} and `cram_addr` = {index, word}, with `wb_sel` high and `cram_we` low. The refill of R3 follows, and `cpu_ready` rises 3+64*(WAIT_CYC+1) cycles after the access is first presented.
- R6: A write hit pulses `cram_we` at `cram_addr` = {index, offset} in the ready cycle and marks the line dirty. A read hit leaves the dirty flag unchanged.
- R7: Each word gets exactly one `mem_stb` pulse, one cycle wide. Successive strobes in one transfer are WAIT_CYC+1 cycles apart.
- R8: `cpu_ready` is high only in the compare state, and there only when `cpu_sel` is low or the access hits. It is low for the whole of miss handling.
- R9: `fill_sel` is high only during a refill and `wb_sel` only during a write-back. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address {tag, index, offset} |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_sel | input | 1 | Access request, held until ready |
| cpu_ready | output | 1 | Access complete / controller idle |
| mem_addr | output | 16 | External memory word address |
| mem_we | output | 1 | 1 = memory write (write-back), 0 = read |
| mem_stb | output | 1 | One-cycle strobe per memory word |
| fill_sel | output | 1 | SRAM write data taken from memory |
| wb_sel | output | 1 | Memory write data taken from SRAM |
| cram_addr | output | 8 | Cache SRAM word address {index, word} |
| cram_we | output | 1 | Cache SRAM write enable |

## Verification
The bench keeps its own tag, valid and dirty model. It drives hits, clean misses and dirty misses that share one index with several tags, so a design that compared only the index or ignored valid would return wrong hits and produce no memory traffic. Every strobe is checked for address, direction, word order and spacing. A write-back that used the incoming tag instead of the stored one, or a counter that skipped or repeated a word, shows up as a wrong address or a wrong count. The bench checks that a refill leaves the line clean and that a read hit does not dirty it, by expecting the next miss on that line to be clean, with no write-back and a shorter latency. A reset after dirty lines exist must make those lines miss without any write-back.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    ST_CMP  = 2'd0,
    ST_MISS = 2'd1,
    ST_WB   = 2'd2,
    ST_FILL = 2'd3
  } cc_state_e;
endpackage

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             mark_dirty,
  input  logic             mark_clean,
  input  logic             fill_commit,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  // tag array has no reset so it may map onto distributed RAM
  always_ff @(posedge clk) begin
    if (fill_commit) tag_mem[rd_idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_commit) valid_q[rd_idx] <= 1'b1;
      if (fill_commit || mark_clean) dirty_q[rd_idx] <= 1'b0;
      else if (mark_dirty)           dirty_q[rd_idx] <= 1'b1;
    end
  end

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/cc_xfer_seq.sv
module cc_xfer_seq #(
  parameter int OFF_W    = 5,
  parameter int WAIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [OFF_W-1:0] word,
  output logic             strobe_slot,
  output logic             data_slot,
  output logic             line_done
);
  localparam int PH_W = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(WAIT_CYC);

  logic [PH_W-1:0] phase_q;
  logic [OFF_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
      word_q  <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      word_q  <= word_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign word        = word_q;
  assign strobe_slot = run && (phase_q == '0);
  assign data_slot   = run && (phase_q == PH_LAST);
  assign line_done   = data_slot && (word_q == {OFF_W{1'b1}});
endmodule

// File: rtl/cc_fsm.sv
module cc_fsm
  import cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cpu_sel,
  input  logic      hit,
  input  logic      line_dirty,
  input  logic      line_done,
  output cc_state_e state
);
  cc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CMP:  if (cpu_sel && !hit) state_d = ST_MISS;
      ST_MISS: state_d = line_dirty ? ST_WB : ST_FILL;
      ST_WB:   if (line_done) state_d = ST_MISS;
      ST_FILL: if (line_done) state_d = ST_CMP;
      default: state_d = ST_CMP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_CMP;
    else     state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/cache_ctrl_top.sv
module cache_ctrl_top
  import cc_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int IDX_W    = 3,
  parameter int OFF_W    = 5,
  parameter int WAIT_CYC = 2,
  localparam int ADDR_W  = TAG_W + IDX_W + OFF_W,
  localparam int CRAM_W  = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_sel,
  output logic              cpu_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_stb,
  output logic              fill_sel,
  output logic              wb_sel,
  output logic [CRAM_W-1:0] cram_addr,
  output logic              cram_we
);
  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFF_W-1:0] a_off;

  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx = cpu_addr[OFF_W +: IDX_W];
  assign a_off = cpu_addr[OFF_W-1:0];

  cc_state_e        state;
  logic [TAG_W-1:0] s_tag;
  logic             s_valid, s_dirty, hit;
  logic             in_cmp, in_wb, in_fill, run;
  logic [OFF_W-1:0] word;
  logic             strobe_slot, data_slot, line_done;
  logic             write_hit;

  assign hit       = s_valid && (s_tag == a_tag);
  assign in_cmp    = (state == ST_CMP);
  assign in_wb     = (state == ST_WB);
  assign in_fill   = (state == ST_FILL);
  assign run       = in_wb || in_fill;
  assign write_hit = in_cmp && cpu_sel && cpu_we && hit;

  cc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) tags_i (
    .clk         (clk),
    .rst         (rst),
    .rd_idx      (a_idx),
    .rd_tag      (s_tag),
    .rd_valid    (s_valid),
    .rd_dirty    (s_dirty),
    .mark_dirty  (write_hit),
    .mark_clean  (in_wb && line_done),
    .fill_commit (in_fill && line_done),
    .fill_tag    (a_tag)
  );

  cc_xfer_seq #(.OFF_W(OFF_W), .WAIT_CYC(WAIT_CYC)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .word        (word),
    .strobe_slot (strobe_slot),
    .data_slot   (data_slot),
    .line_done   (line_done)
  );

  cc_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_sel    (cpu_sel),
    .hit        (hit),
    .line_dirty (s_valid && s_dirty),
    .line_done  (line_done),
    .state      (state)
  );

  assign cpu_ready = in_cmp && (!cpu_sel || hit);
  assign mem_stb   = run && strobe_slot;
  assign mem_we    = in_wb;
  assign mem_addr  = {(in_wb ? s_tag : a_tag), a_idx, word};
  assign fill_sel  = in_fill;
  assign wb_sel    = in_wb;
  assign cram_addr = {a_idx, (run ? word : a_off)};
  assign cram_we   = write_hit || (in_fill && data_slot);
endmodule

// File: rtl/cc_ctrl_chk.sv
module cc_ctrl_chk #(
  parameter int WAIT_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic cpu_ready,
  input logic mem_we,
  input logic mem_stb,
  input logic fill_sel,
  input logic wb_sel,
  input logic cram_we
);
  // R9
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_sel && wb_sel));

  // R7
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_stb && (WAIT_CYC > 0)) |=> !mem_stb);

  // R8
  rdy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (!mem_stb && !fill_sel && !wb_sel));

  // R5
  wb_no_cram_chk: assert property (@(posedge clk) disable iff (rst)
    wb_sel |-> !cram_we);

  // R5
  wb_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_sel && mem_stb) |-> mem_we);

  // R4
  fill_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_sel && mem_stb) |-> !mem_we);

  // R8
  miss_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_sel) |-> !cpu_ready);
endmodule

bind cache_ctrl_top cc_ctrl_chk #(.WAIT_CYC(WAIT_CYC)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_ready (cpu_ready),
  .mem_we    (mem_we),
  .mem_stb   (mem_stb),
  .fill_sel  (fill_sel),
  .wb_sel    (wb_sel),
  .cram_we   (cram_we)
);

// File: tb/cache_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module cache_ctrl_top_tb_top;
  localparam int WAIT  = 2;
  localparam int WORDS = 32;
  localparam int LIMIT = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_sel = 1'b0;
  logic        cpu_ready, mem_we, mem_stb, fill_sel, wb_sel, cram_we;
  logic [15:0] mem_addr;
  logic [7:0]  cram_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] ref_tag [8];
  bit         ref_valid [8];
  bit         ref_dirty [8];

  always #4 clk = ~clk;

  cache_ctrl_top #(.WAIT_CYC(WAIT)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_sel(cpu_sel), .cpu_ready(cpu_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_stb(mem_stb), .fill_sel(fill_sel),
    .wb_sel(wb_sel), .cram_addr(cram_addr), .cram_we(cram_we)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_latency(input int kind);
    if (kind == 0) return 0;
    if (kind == 1) return 2 + WORDS * (WAIT + 1);
    return 3 + 2 * WORDS * (WAIT + 1);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cpu_sel = 1'b0; cpu_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ref_valid[i] = 1'b0; ref_dirty[i] = 1'b0; ref_tag[i] = '0;
    end
    #1;
    check(cpu_ready == 1'b1, "R2", "ready idle after reset", cpu_ready, 1);
    check(mem_stb == 1'b0 && cram_we == 1'b0, "R2", "no strobe/we after reset",
          {mem_stb, cram_we}, 0);
    check(fill_sel == 1'b0 && wb_sel == 1'b0, "R2", "selects low after reset",
          {fill_sel, wb_sel}, 0);
  endtask

  // kind: 0 hit, 1 clean miss, 2 dirty miss
  task automatic do_access(input logic [7:0] tg, input logic [2:0] ix,
                           input logic [4:0] of, input bit wr);
    int kind, k, wn, fn, wen, hwn, last_w, last_f;
    logic [7:0] old;
    old = ref_tag[ix];
    if (ref_valid[ix] && ref_tag[ix] == tg) kind = 0;
    else if (ref_valid[ix] && ref_dirty[ix]) kind = 2;
    else kind = 1;
    @(negedge clk);
    cpu_addr = {tg, ix, of}; cpu_we = wr; cpu_sel = 1'b1;
    #1;
    k = 0; wn = 0; fn = 0; wen = 0; hwn = 0; last_w = 0; last_f = 0;
    forever begin
      check(!(fill_sel && wb_sel), "R9", "selects exclusive", {fill_sel, wb_sel}, 0);
      if (mem_stb) begin
        if (mem_we) begin
          check(wb_sel == 1'b1, "R9", "wb_sel on write strobe", wb_sel, 1);
          check(mem_addr == {old, ix, 5'(wn)}, "R5", "write-back mem_addr",
                mem_addr, {old, ix, 5'(wn)});
          check(cram_addr == {ix, 5'(wn)}, "R5", "write-back cram_addr",
                cram_addr, {ix, 5'(wn)});
          if (wn > 0) check(k - last_w == WAIT + 1, "R7", "write strobe gap",
                            k - last_w, WAIT + 1);
          last_w = k; wn++;
        end else begin
          check(fill_sel == 1'b1, "R9", "fill_sel on read strobe", fill_sel, 1);
          check(mem_addr == {tg, ix, 5'(fn)}, "R3", "refill mem_addr",
                mem_addr, {tg, ix, 5'(fn)});
          if (fn > 0) check(k - last_f == WAIT + 1, "R7", "read strobe gap",
                            k - last_f, WAIT + 1);
          last_f = k; fn++;
        end
      end
      if (cram_we) begin
        if (fill_sel) begin
          check(cram_addr == {ix, 5'(wen)}, "R4", "refill cram_addr",
                cram_addr, {ix, 5'(wen)});
          check(k - last_f == WAIT, "R4", "refill write delay", k - last_f, WAIT);
          wen++;
        end else begin
          check(cpu_ready == 1'b1, "R6", "hit write in ready cycle", cpu_ready, 1);
          check(cram_addr == {ix, of}, "R6", "hit write cram_addr",
                cram_addr, {ix, of});
          hwn++;
        end
      end
      if (cpu_ready || k > LIMIT) break;
      @(negedge clk); #1; k++;
    end
    check(k == exp_latency(kind), (kind == 2) ? "R5" : (kind == 1) ? "R3" : "R1",
          "cycles to ready", k, exp_latency(kind));
    check(wn == ((kind == 2) ? WORDS : 0), "R5", "write strobe count", wn,
          (kind == 2) ? WORDS : 0);
    check(fn == ((kind != 0) ? WORDS : 0), "R3", "read strobe count", fn,
          (kind != 0) ? WORDS : 0);
    check(wen == ((kind != 0) ? WORDS : 0), "R4", "refill write count", wen,
          (kind != 0) ? WORDS : 0);
    check(hwn == (wr ? 1 : 0), "R6", "hit write count", hwn, wr ? 1 : 0);
    @(negedge clk);
    cpu_sel = 1'b0; #1;
    check(cpu_ready == 1'b1 && mem_stb == 1'b0, "R8", "ready when deselected",
          {cpu_ready, mem_stb}, 2'b10);
    if (kind != 0) begin
      ref_tag[ix] = tg; ref_valid[ix] = 1'b1; ref_dirty[ix] = 1'b0;
    end
    if (wr) ref_dirty[ix] = 1'b1;
  endtask

  initial begin
    #(64'd200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] tag_set [4];
    tag_set[0] = 8'h00; tag_set[1] = 8'h12; tag_set[2] = 8'hA5; tag_set[3] = 8'hFF;
    void'($urandom(32'h5EED_0042));
    do_reset();                          // R2
    do_access(8'h12, 3'd3, 5'd0, 1'b0);  // R3 clean miss after reset
    do_access(8'h12, 3'd3, 5'd0, 1'b0);  // R1 read hit
    do_access(8'h12, 3'd3, 5'd17, 1'b0); // R1 hit other offset
    do_access(8'h12, 3'd3, 5'd9, 1'b1);  // R6 write hit
    do_access(8'h34, 3'd3, 5'd2, 1'b0);  // R5 dirty miss with old tag
    do_access(8'h34, 3'd3, 5'd2, 1'b0);  // R6 read hit keeps clean
    do_access(8'h56, 3'd3, 5'd5, 1'b0);  // R4 refill left line clean
    do_access(8'h12, 3'd4, 5'd1, 1'b0);  // R1 index distinguishes lines
    do_access(8'hFF, 3'd7, 5'd31, 1'b1); // R6 write miss then write
    do_access(8'h00, 3'd7, 5'd0, 1'b0);  // R5 dirty victim tag FF
    do_access(8'hA5, 3'd0, 5'd3, 1'b1);
    do_reset();                          // R2 reset drops dirty lines
    do_access(8'hA5, 3'd0, 5'd3, 1'b0);  // R2 miss, no write-back
    for (int n = 0; n < 50; n++) begin
      do_access(tag_set[$urandom % 4], 3'($urandom % 8), 5'($urandom % 32),
                1'($urandom % 2));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule